// File: doc/BRIEF.md
# Multi-Mode Operand Fetch and Add Unit

This unit runs one two-operand add at a time. The first addend always comes from a register. The second addend is fetched under one of eight addressing modes. It may come straight from a register, from the instruction constant, or from data memory. A memory read can take its address from a base register plus a displacement, from a register alone, from a fixed address, from the program counter plus a displacement, or from a base plus a displacement plus an index register times four. In the pointer-chasing mode, two memory reads run back to back: the first fetches a pointer and the second fetches the operand at that pointer. The sum is written to a destination register in the unit's own register file.

A controller raises `start` for one cycle with the mode code, the register indices, the constant, a fixed address and the current program counter. The unit then sequences zero, one or two reads on a synchronous read port that has one cycle of latency. It writes the result back and pulses `done`, with the written index and value visible alongside. Registers receive values only through the unit's own results. The usual way to load a constant is immediate mode with register 0 as the first source.

Top module: `opf_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `mem_rd_en` are 0 and every register holds zero.
- R2: Mode code 0 (register): the operand is register `srcb_idx`. No memory read is made.
- R3: Mode code 1 (immediate): the operand is `imm`. No memory read is made.
- R4: Mode code 2 (displacement): the operand is one read at address `imm + reg[srcb_idx]`.
- R5: Mode code 3 (register-indirect) reads once at address `reg[srcb_idx]`. Mode code 4 (absolute) reads once at address `abs_addr`.
- R6: Mode code 5 (memory-indirect): a first read at `reg[srcb_idx]` returns a pointer. Its low ADDR_W bits address a second read, which returns the operand. Exactly two reads are made, in consecutive cycles.
- R7: Mode code 6 (PC-relative): the operand is one read at address `imm + pc`, with `imm` treated as two's complement.
- R8: Mode code 7 (scaled): the operand is one read at address `imm + reg[srcb_idx] + 4*reg[srcx_idx]`.
- R9: Count the cycle in which `start` is accepted as cycle 0. For N memory reads, `done` is high in cycle 2+N only, and `busy` is high in cycles 1 to 1+N. `wb_idx` equals the destination index and `wb_data` equals `reg[srca_idx]` plus the operand. An operation started in the `done` cycle sees the new value.
- R10: A `start` pulse raised while `busy` is 1 is ignored. It produces no `done` and no register write.
- R11: Register 0 always reads as zero. A result aimed at it still pulses `done` and shows its value on `wb_data`, but it is not stored.
- R12: Memory addresses are the low ADDR_W bits of the computed sum, so the address wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| mode | input | 3 | Addressing mode code, 0 to 7 |
| dst_idx | input | IDX_W | Destination register index |
| srca_idx | input | IDX_W | First addend register |
| srcb_idx | input | IDX_W | Second register / base register |
| srcx_idx | input | IDX_W | Index register for scaled mode |
| imm | input | DATA_W | Immediate or displacement |
| abs_addr | input | ADDR_W | Fixed address for absolute mode |
| pc | input | ADDR_W | Current program counter |
| mem_rd_en | output | 1 | Data memory read request |
| mem_rd_addr | output | ADDR_W | Data memory read address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after the request |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle pulse after write-back |
| wb_idx | output | IDX_W | Register written, valid with `done` |
| wb_data | output | DATA_W | Value written, valid with `done` |

## Verification
Each mode is run with a distinct base, index and constant. Because the memory returns a value that is a distinct function of its address, a wrong address term (base, displacement, index scaling, program counter) shows up as a wrong sum. The pointer mode loads a pointer that differs from its own address, which separates one read from two chained reads. A negative displacement and an address sum past 2^ADDR_W check the wrap. Writes to register 0, a start raised mid-operation, and operations that start right after a result check forwarding of results, filtering of writes to register 0 and the idle-only handshake.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [2:0] {
    AM_REG   = 3'd0,
    AM_IMM   = 3'd1,
    AM_DISP  = 3'd2,
    AM_RIND  = 3'd3,
    AM_ABS   = 3'd4,
    AM_MIND  = 3'd5,
    AM_PCREL = 3'd6,
    AM_SCALE = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_FIN  = 2'd3
  } state_e;
endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int NRD    = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]  rd_data,
  input  logic                        we,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wr_idx != '0) begin
      regs[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = (rd_idx[p] == '0) ? '0 : regs[rd_idx[p]];
  end

  // R11: a write aimed at register 0 leaves register 0 at zero
  assert_r0_stays_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (we && wr_idx == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/opf_agen.sv
module opf_agen
  import opf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  amode_e              mode,
  input  logic [DATA_W-1:0]   imm,
  input  logic [ADDR_W-1:0]   abs_addr,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [DATA_W-1:0]   base,
  input  logic [DATA_W-1:0]   index,
  output logic [ADDR_W-1:0]   ea,
  output logic [1:0]          nreads
);
  logic [DATA_W-1:0] sum;

  always_comb begin
    sum    = '0;
    nreads = 2'd1;
    unique case (mode)
      AM_REG, AM_IMM: nreads = 2'd0;
      AM_DISP:  sum = imm + base;
      AM_RIND:  sum = base;
      AM_ABS:   sum = DATA_W'(abs_addr);
      AM_MIND: begin
        sum    = base;
        nreads = 2'd2;
      end
      AM_PCREL: sum = imm + DATA_W'(pc);
      AM_SCALE: sum = imm + base + (index << 2);
      default:  nreads = 2'd0;
    endcase
  end

  assign ea = sum[ADDR_W-1:0];
endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        nreads,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [DATA_W-1:0] a_val,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  state_e            state;
  logic              two_q, memop_q;
  logic [ADDR_W-1:0] ea_q;
  logic [DATA_W-1:0] opnd_q, a_q;
  logic [IDX_W-1:0]  dst_q;

  assign busy        = (state != ST_IDLE);
  assign mem_rd_en   = (state == ST_RD1) || (state == ST_RD2);
  assign mem_rd_addr = (state == ST_RD2) ? mem_rd_data[ADDR_W-1:0] : ea_q;
  assign wr_en       = (state == ST_FIN);
  assign wr_idx      = dst_q;
  assign wr_data     = a_q + (memop_q ? mem_rd_data : opnd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      two_q   <= 1'b0;
      memop_q <= 1'b0;
      ea_q    <= '0;
      opnd_q  <= '0;
      a_q     <= '0;
      dst_q   <= '0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          two_q   <= (nreads == 2'd2);
          memop_q <= (nreads != 2'd0);
          ea_q    <= ea;
          opnd_q  <= opnd_in;
          a_q     <= a_val;
          dst_q   <= dst_idx;
          state   <= (nreads == 2'd0) ? ST_FIN : ST_RD1;
        end
        ST_RD1: state <= two_q ? ST_RD2 : ST_FIN;
        ST_RD2: state <= ST_FIN;
        ST_FIN: begin
          done    <= 1'b1;
          wb_idx  <= dst_q;
          wb_data <= wr_data;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: done lasts a single cycle and the unit is idle when it shows
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R10: the unit becomes busy only from an accepted start
  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R10: a start raised mid-operation leaves the latched destination alone
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != ST_FIN) |=> $stable(dst_q));
  // R6: the chained read directly follows the pointer read
  assert_chain_order_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD2) |-> $past(state == ST_RD1));
endmodule

// File: rtl/opf_unit.sv
module opf_unit
  import opf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  srca_idx,
  input  logic [IDX_W-1:0]  srcb_idx,
  input  logic [IDX_W-1:0]  srcx_idx,
  input  logic [DATA_W-1:0] imm,
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic [ADDR_W-1:0] pc,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  localparam int NRD = 3;

  amode_e                      mode_e;
  logic [NRD-1:0][IDX_W-1:0]   rd_idx;
  logic [NRD-1:0][DATA_W-1:0]  rd_data;
  logic [ADDR_W-1:0]           ea;
  logic [1:0]                  nreads;
  logic [DATA_W-1:0]           opnd_in;
  logic                        wr_en;
  logic [IDX_W-1:0]            wr_idx;
  logic [DATA_W-1:0]           wr_data;

  assign mode_e  = amode_e'(mode);
  assign rd_idx  = {srcx_idx, srcb_idx, srca_idx};
  assign opnd_in = (mode_e == AM_REG) ? rd_data[1] : imm;

  opf_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
    .we(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  opf_agen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agen (
    .mode(mode_e), .imm(imm), .abs_addr(abs_addr), .pc(pc),
    .base(rd_data[1]), .index(rd_data[2]), .ea(ea), .nreads(nreads)
  );

  opf_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .nreads(nreads), .ea(ea),
    .opnd_in(opnd_in), .a_val(rd_data[0]), .dst_idx(dst_idx),
    .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // R2: register and immediate modes never touch memory
  assert_no_read_direct_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mode_e == AM_REG || mode_e == AM_IMM)) |=> !mem_rd_en);
endmodule

// File: tb/opf_unit_tb.sv
module opf_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int NREG   = 16;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [2:0]        mode = '0;
  logic [IDX_W-1:0]  dst_idx = '0, srca_idx = '0, srcb_idx = '0, srcx_idx = '0;
  logic [DATA_W-1:0] imm = '0;
  logic [ADDR_W-1:0] abs_addr = '0, pc = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic              busy, done;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;

  int tests = 0;
  int fails = 0;
  logic [DATA_W-1:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  opf_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .dst_idx(dst_idx),
    .srca_idx(srca_idx), .srcb_idx(srcb_idx), .srcx_idx(srcx_idx), .imm(imm),
    .abs_addr(abs_addr), .pc(pc), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .wb_idx(wb_idx),
    .wb_data(wb_data)
  );

  function automatic logic [DATA_W-1:0] memf(input logic [ADDR_W-1:0] a);
    return 32'h0100_0000 + DATA_W'(a) * 32'd37 + 32'd5;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input int d, input int a, input int b,
                        input int x, input logic [DATA_W-1:0] k,
                        input logic [ADDR_W-1:0] ab, input logic [ADDR_W-1:0] p,
                        input string tag, input bit poke);
    logic [DATA_W-1:0] av, bv, xv, s, opnd, expv;
    logic [ADDR_W-1:0] ad;
    int n, lat, reads;
    av = model[a]; bv = model[b]; xv = model[x];
    n = 1; s = '0; opnd = '0;
    case (m)
      3'd0: begin n = 0; opnd = bv; end
      3'd1: begin n = 0; opnd = k; end
      3'd2: s = k + bv;
      3'd3: s = bv;
      3'd4: s = DATA_W'(ab);
      3'd5: begin s = bv; n = 2; end
      3'd6: s = k + DATA_W'(p);
      default: s = k + bv + xv * 4;
    endcase
    ad = s[ADDR_W-1:0];
    if (n == 1) opnd = memf(ad);
    if (n == 2) opnd = memf(memf(ad)[ADDR_W-1:0]);
    expv = av + opnd;
    lat = 2 + n;
    reads = 0;
    @(negedge clk);
    start = 1'b1; mode = m; dst_idx = IDX_W'(d); srca_idx = IDX_W'(a);
    srcb_idx = IDX_W'(b); srcx_idx = IDX_W'(x); imm = k; abs_addr = ab; pc = p;
    for (int c = 1; c <= lat + 1; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && c == 1) begin
        start = 1'b1; mode = 3'd1; dst_idx = 4'd13; srca_idx = 4'd0; imm = 32'd999;
      end
      if (mem_rd_en) reads++;
      chk(done == (c == lat), {tag, " R9 done timing"}, 32'(done), 32'(c == lat));
      chk(busy == (c < lat), {tag, " R9 busy window"}, 32'(busy), 32'(c < lat));
      if (c == lat) begin
        chk(wb_idx == IDX_W'(d), {tag, " R9 wb_idx"}, 32'(wb_idx), 32'(d));
        chk(wb_data == expv, {tag, " wb_data"}, wb_data, expv);
      end
    end
    chk(reads == n, {tag, " read count"}, 32'(reads), 32'(n));
    if (d != 0) model[d] = expv;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_en, "R1 reset outputs", {busy, done, mem_rd_en}, 0);
    rst = 1'b0;
    run_op(3'd0, 1, 2, 3, 0, 0, 0, 0, "R1 regs zero after reset", 0);
    run_op(3'd1, 1, 0, 0, 0, 32'd100, 0, 0, "R3 imm", 0);
    run_op(3'd1, 2, 0, 0, 0, 32'd40, 0, 0, "R3 imm", 0);
    run_op(3'd1, 3, 0, 0, 0, 32'd3, 0, 0, "R3 imm", 0);
    run_op(3'd1, 4, 0, 0, 0, 32'd5, 0, 0, "R3 imm", 0);
    run_op(3'd1, 5, 1, 0, 0, 32'd7, 0, 0, "R3 imm with base", 0);
    run_op(3'd0, 6, 1, 2, 0, 0, 0, 0, "R2 reg", 0);
    run_op(3'd2, 7, 1, 2, 0, 32'd12, 0, 0, "R4 disp", 0);
    run_op(3'd3, 8, 2, 1, 0, 0, 0, 0, "R5 reg-indirect", 0);
    run_op(3'd4, 9, 0, 0, 0, 0, 10'd777, 0, "R5 absolute", 0);
    run_op(3'd5, 10, 1, 4, 0, 0, 0, 0, "R6 mem-indirect", 0);
    run_op(3'd6, 11, 2, 0, 0, 32'hFFFF_FFF0, 0, 10'd20, "R7 pc-relative", 0);
    run_op(3'd7, 12, 2, 1, 3, 32'd8, 0, 0, "R8 scaled", 0);
    run_op(3'd2, 14, 0, 1, 0, 32'd1020, 0, 0, "R12 address wrap", 0);
    run_op(3'd1, 0, 0, 0, 0, 32'd55, 0, 0, "R11 write to r0", 0);
    run_op(3'd0, 15, 0, 0, 0, 0, 0, 0, "R11 r0 reads zero", 0);
    run_op(3'd5, 13, 6, 7, 0, 0, 0, 0, "R10 busy start", 1);
    run_op(3'd0, 14, 13, 0, 0, 0, 0, 0, "R10 ignored start left r13", 0);
    run_op(3'd0, 15, 13, 13, 0, 0, 0, 0, "R9 back-to-back forward", 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule